// File: doc/BRIEF.md
# Segmented-Carry Pipelined Up-Counter

This block is a free-running binary up-counter meant to close timing at a 200 MHz clock. A single adder across the full count width has a carry chain that is too long for a 5 ns period. The count is therefore split into narrow slices of about eight bits. Each slice increments on its own, and it passes a registered carry to the next slice up. Because of this, the higher slices see a given enable one cycle later per slice.

To hide that skew, each slice's value goes through its own delay line before it reaches a common output register. The lowest slice gets the longest delay and the top slice gets none. The result is an exact binary count that trails the enable input by a fixed latency equal to the number of slices. A settled flag tells the consumer when that latency has passed since the enable was last high, so the value it reads is final. A synchronous clear empties every slice, every carry and every delay stage in one edge. The count wraps to zero on overflow.

Top module: `pipelined_counter`

## Requirements
- R1: With NSEG = ceil(WIDTH/SEG_W) (default WIDTH 31, SEG_W 8, NSEG 4), `count_o` after clock edge n equals the number of edges from the last clear through edge n-NSEG at which `en` was sampled 1, modulo 2^WIDTH.
- R2: A single enable pulse first shows on `count_o` exactly NSEG edges after the edge that sampled it, and no earlier.
- R3: After `en` falls, `count_o` may keep rising for up to NSEG-1 further edges. It then holds its value while `en` stays low.
- R4: `clr` sampled 1 at an edge sets `count_o` to 0 and `settled_o` to 1 after that edge. Every enable sampled at or before that edge, including one at the clear edge itself, is discarded and never appears later.
- R5: On overflow the count wraps from 2^WIDTH-1 to 0, with no saturation.
- R6: `settled_o` is 1 exactly when `en` was sampled 0 at each of the last NSEG edges, where edges at or before the latest clear count as 0. An edge with `en` = 1 and `clr` = 0 drives it to 0.
- R7: Between consecutive edges without a clear, `count_o` changes by either 0 or +1 modulo 2^WIDTH.
- R8: While the asynchronous active-low `rst_n` is 0, `count_o` is 0 and `settled_o` is 1.
- R9: A carry that crosses a slice boundary (for example 15 to 16, or 255 to 256) appears as a single +1 step, with no intermediate wrong value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all slices, carries and delay stages |
| en | input | 1 | Count enable, sampled each rising edge |
| count_o | output | WIDTH | Aligned count value, NSEG cycles behind `en` |
| settled_o | output | 1 | High once no enable is still in flight |

## Verification
`count_o` after edge n is due to reflect enables through edge n-NSEG. `settled_o` after edge n is due to reflect the enables at edges n-NSEG+1 through n. A clear takes effect on the very next edge.

The bench keeps a shifted history of its own running total and enable bits, one entry per edge. It compares each output against the entry that is exactly NSEG edges old. Sampling happens at the falling edge that follows each rising edge, and new inputs are driven only after that sample.

A narrow 12-bit instance with three slices makes wrap-around reachable within the run. The default 31-bit instance shares its inputs and is checked against a latency of four.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    // Number of slices needed to cover a count of the given width.
    function automatic int seg_count(input int width, input int seg_w);
        return (width + seg_w - 1) / seg_w;
    endfunction

    // Number of live bits in the topmost slice.
    function automatic int top_bits(input int width, input int seg_w);
        return width - (seg_count(width, seg_w) - 1) * seg_w;
    endfunction

endpackage

// File: rtl/pcnt_segment.sv
// One slice of the counter: increments when its input carry (or enable) is set
// and registers the carry it produces for the slice above.
module pcnt_segment #(
    parameter int W     = 8,
    parameter int ACT_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);

    localparam logic [W-1:0] MASK = W'((64'd1 << ACT_W) - 64'd1);

    typedef struct packed {
        logic [W-1:0] val;
        logic         carry;
    } seg_t;

    seg_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.carry = 1'b0;
        if (inc) begin
            s_d.val   = (s_q.val + W'(1)) & MASK;
            s_d.carry = (s_q.val == MASK);
        end
        if (clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign val   = s_q.val;
    assign carry = s_q.carry;

    // R5: a slice never holds bits beyond its live width
    a_r5_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (val & ~MASK) == '0);

    // R9: a produced carry always coincides with the slice having rolled to zero
    a_r9_carry_roll: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (val == '0));

endmodule

// File: rtl/pcnt_skew.sv
// Delay line that holds a slice value back until its higher neighbours catch up.
module pcnt_skew #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } skew_t;

    skew_t k_d, k_q;

    always_comb begin
        k_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            k_d.stg[i] = k_q.stg[i-1];
        end
        if (clr) begin
            k_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= '0;
        end else begin
            k_q <= k_d;
        end
    end

    assign dout = k_q.stg[DEPTH-1];

    // R4: a clear empties the delay line on the next edge
    a_r4_skew_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dout == '0));

endmodule

// File: rtl/pipelined_counter.sv
module pipelined_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 31,
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count_o,
    output logic             settled_o
);

    localparam int NSEG  = seg_count(WIDTH, SEG_W);
    localparam int TOP_W = top_bits(WIDTH, SEG_W);
    localparam int PAD_W = NSEG * SEG_W;

    logic [NSEG-1:0]  inc;
    logic [NSEG-1:0]  carry;
    logic [SEG_W-1:0] seg_val [NSEG];
    logic [PAD_W-1:0] aligned;

    assign inc[0] = en;

    for (genvar k = 0; k < NSEG; k++) begin : g_slice
        if (k > 0) begin : g_chain
            assign inc[k] = carry[k-1];
        end

        pcnt_segment #(
            .W     (SEG_W),
            .ACT_W ((k == NSEG - 1) ? TOP_W : SEG_W)
        ) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[k]),
            .val   (seg_val[k]),
            .carry (carry[k])
        );

        if (k < NSEG - 1) begin : g_delay
            pcnt_skew #(
                .W     (SEG_W),
                .DEPTH (NSEG - 1 - k)
            ) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .din   (seg_val[k]),
                .dout  (aligned[k*SEG_W +: SEG_W])
            );
        end else begin : g_direct
            assign aligned[k*SEG_W +: SEG_W] = seg_val[k];
        end
    end

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic [NSEG-1:0]  hist;
    } top_t;

    top_t t_d, t_q;

    always_comb begin
        t_d.count   = aligned[WIDTH-1:0];
        t_d.hist[0] = en;
        for (int i = 1; i < NSEG; i++) begin
            t_d.hist[i] = t_q.hist[i-1];
        end
        if (clr) begin
            t_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign count_o   = t_q.count;
    assign settled_o = (t_q.hist == '0);

    // R4: clear zeroes the count and marks it settled on the next edge
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_o == '0 && settled_o));

    // R7: the aligned count never jumps by more than one
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count_o == $past(count_o) || count_o == $past(count_o) + WIDTH'(1)));

    // R3: once settled, the count holds until a new enable or a clear
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_o && !clr) |=> $stable(count_o));

    // R6: a sampled enable means work is in flight
    a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> !settled_o);

    // R5: the top slice carries out only as it rolls over to zero
    a_r5_top_carry: assert property (@(posedge clk) disable iff (!rst_n)
        carry[NSEG-1] |-> (seg_val[NSEG-1] == '0));

    if (PAD_W > WIDTH) begin : g_pad_chk
        // R5: padding bits above the count width stay zero
        a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            aligned[PAD_W-1:WIDTH] == '0);
    end

endmodule

// File: tb/pipelined_counter_tb.sv
module pipelined_counter_tb;

    localparam int SW = 12;
    localparam int SS = 4;
    localparam int SL = 3;
    localparam int WW = 31;
    localparam int WS = 8;
    localparam int WL = 4;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic clr   = 1'b0;
    logic en    = 1'b0;

    logic [SW-1:0] cnt_s;
    logic          settled_s;
    logic [WW-1:0] cnt_w;
    logic          settled_w;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pipelined_counter #(.WIDTH(SW), .SEG_W(SS)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .count_o(cnt_s), .settled_o(settled_s)
    );

    pipelined_counter #(.WIDTH(WW), .SEG_W(WS)) u_wide (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .count_o(cnt_w), .settled_o(settled_w)
    );

    // Behavioural model: running total and enable bits, one entry per edge.
    longint run;
    longint hist [0:7];
    bit     enh  [0:7];
    bit     clr_edge;

    initial begin
        run = 0;
        clr_edge = 1'b0;
        for (int i = 0; i < 8; i++) begin
            hist[i] = 0;
            enh[i]  = 1'b0;
        end
    end

    always @(posedge clk) begin
        clr_edge = (!rst_n || clr);
        if (!rst_n || clr) begin
            run = 0;
            for (int i = 0; i < 8; i++) begin
                hist[i] = 0;
                enh[i]  = 1'b0;
            end
        end else begin
            for (int i = 7; i > 0; i--) begin
                hist[i] = hist[i-1];
                enh[i]  = enh[i-1];
            end
            if (en) run = run + 1;
            hist[0] = run;
            enh[0]  = en;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit idle_for(input int lat);
        bit r = 1'b1;
        for (int i = 0; i < lat; i++) if (enh[i]) r = 1'b0;
        return r;
    endfunction

    longint prev_s = 0;
    bit saw_wrap = 1'b0;
    bit saw_16   = 1'b0;
    bit saw_256  = 1'b0;

    // Advance one edge and compare every output at the following falling edge.
    task automatic tick();
        longint exp_s, exp_w, diff;
        @(negedge clk);
        exp_s = hist[SL] % 4096;
        exp_w = hist[WL] % 64'h8000_0000;
        check(cnt_s == exp_s, "R1 narrow count", cnt_s, exp_s);
        check(cnt_w == exp_w, "R1 wide count", cnt_w, exp_w);
        check(settled_s == idle_for(SL), "R6 narrow settled", settled_s, idle_for(SL));
        check(settled_w == idle_for(WL), "R6 wide settled", settled_w, idle_for(WL));
        if (!clr_edge) begin
            diff = (longint'(cnt_s) - prev_s + 4096) % 4096;
            check(diff <= 1, "R7 step size", diff, 1);
            if (prev_s == 4095 && cnt_s == 0) saw_wrap = 1'b1;
            if (prev_s == 15 && cnt_s == 16) saw_16 = 1'b1;
            if (prev_s == 255 && cnt_s == 256) saw_256 = 1'b1;
        end
        prev_s = cnt_s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint v0, v_end;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(cnt_s == 0, "R8 reset narrow count", cnt_s, 0);
        check(settled_s == 1'b1, "R8 reset settled", settled_s, 1);
        check(cnt_w == 0, "R8 reset wide count", cnt_w, 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // R2: single pulse latency
        en = 1'b1;
        tick();
        en = 1'b0;
        check(cnt_s == 0, "R2 narrow early", cnt_s, 0);
        for (int i = 1; i < SL; i++) begin
            tick();
            check(cnt_s == 0, "R2 narrow early", cnt_s, 0);
        end
        tick();
        check(cnt_s == 1, "R2 narrow on time", cnt_s, 1);
        check(cnt_w == 0, "R2 wide early", cnt_w, 0);
        tick();
        check(cnt_w == 1, "R2 wide on time", cnt_w, 1);

        // R3: drain after enable falls, then hold
        en = 1'b1;
        repeat (40) tick();
        en = 1'b0;
        v0 = cnt_s;
        repeat (SL) tick();
        v_end = cnt_s;
        check(v_end == 41, "R3 drained total", v_end, 41);
        check(v_end > v0, "R3 still changing after fall", v0, v_end);
        repeat (5) tick();
        check(cnt_s == 41, "R3 holds when idle", cnt_s, 41);
        check(settled_s == 1'b1, "R3 settled when idle", settled_s, 1);

        // Mixed enable pattern
        for (int i = 0; i < 400; i++) begin
            en = 1'($urandom % 2);
            tick();
        end
        en = 1'b0;
        repeat (6) tick();

        // R4: clear during a burst, with enable high at the clear edge
        en = 1'b1;
        repeat (10) tick();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        en  = 1'b0;
        check(cnt_s == 0, "R4 clear narrow", cnt_s, 0);
        check(cnt_w == 0, "R4 clear wide", cnt_w, 0);
        check(settled_s == 1'b1, "R4 clear settled", settled_s, 1);
        repeat (6) tick();
        check(cnt_s == 0, "R4 in-flight discarded", cnt_s, 0);
        check(cnt_w == 0, "R4 in-flight discarded wide", cnt_w, 0);
        en = 1'b1;
        tick();
        en = 1'b0;
        repeat (5) tick();
        check(cnt_s == 1, "R4 counting resumes", cnt_s, 1);

        // R5 and R9: long run across slice boundaries and past wrap
        clr = 1'b1;
        tick();
        clr = 1'b0;
        en  = 1'b1;
        repeat (4200) tick();
        en = 1'b0;
        repeat (6) tick();
        check(saw_wrap, "R5 wrap 4095 to 0", saw_wrap, 1);
        check(cnt_s == 104, "R5 count after wrap", cnt_s, 104);
        check(cnt_w == 4200, "R1 wide long total", cnt_w, 4200);
        check(saw_16, "R9 boundary 15 to 16", saw_16, 1);
        check(saw_256, "R9 boundary 255 to 256", saw_256, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule